// File: doc/BRIEF.md
# Fuse Mirror Register Loader

This block sits between a one-time-programmable fuse array of 96 bits (twelve bytes) and the volatile register bank that mirrors it. When power-on reset is released, the block reads the fuses one byte per cycle into twelve mirror bytes. Once the last byte has landed, it raises a done flag and drops the array's power enable. The rest of the chip then reads trim, configuration and serial-number bytes from the mirrors through a small byte-addressed bus with sixteen locations. The fuses themselves are not read again during normal operation.

Software can reload every mirror from the fuses at any time by writing a command bit. In test mode it may also overwrite mirror bytes, and such writes are volatile. Two bytes of the array, sixteen bits in all, are reserved for the customer. A program command sets one of those bits in the fuses and in the mirror at the same time. A lock bit inside the customer bytes closes them to further programming. A program command that is refused sets a sticky error flag.

Top module: `otp_mirror_ctrl`

## Requirements
- R1: While reset is held, `boot_done` and `bus_ready` are 0, `fuse_pwr_en` is 1, and the status location reads 0x02.
- R2: After reset is released, the fuses are read at addresses 0 to 11, one per cycle, with data returned one cycle after each request. `boot_done` rises on the 13th rising edge after release. Every mirror byte then equals its fuse byte.
- R3: `fuse_pwr_en` is 1 exactly while a copy is running. It falls in the same cycle that the copy completes, and a fuse read is never requested while it is low.
- R4: While `bus_ready` is 0, reads of mirror locations 0x00–0x0B return 0. `bus_ready` stays 0 until the first copy is complete.
- R5: A bus write to locations 0x00–0x0B changes the mirror byte only while `test_mode` is 1. With `test_mode` at 0 the write is ignored.
- R6: Writing 1 to bit 0 of location 0x0C starts a reload. During the reload the power is on and `bus_ready` is 0. The reload lasts 13 cycles and restores every mirror byte from the fuses, replacing any test-mode writes.
- R7: All bus writes made while `bus_ready` is 0 are ignored. This includes a second reload command and program commands, and it leaves the length of the reload in progress unchanged.
- R8: A fuse bit that has never been programmed reads as 0. On a fresh array, customer bytes 0x08 and 0x09 read 0x00.
- R9: Writing location 0x0D programs one bit. The target byte index is in data bits [6:3] and the bit index in bits [2:0]. A valid request produces a single-cycle `fuse_prog_en` pulse that carries the target. It also sets that mirror bit, leaves the other bits unchanged, and survives a later reload.
- R10: A program request whose target byte lies outside 0x08–0x09 is ignored: there is no pulse and no mirror change. It also sets the error flag, which stays set until reset, including across reloads.
- R11: Bit 7 of byte 0x09 is the lock. Once that bit is set, every program request is refused as described in R10.
- R12: Location 0x0C reads {5'b0, error, busy, done} in bits [7:0]. Locations 0x0D–0x0F read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| test_mode | input | 1 | Enables volatile mirror writes |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register location |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| bus_ready | output | 1 | Mirrors valid and bus writes accepted |
| fuse_pwr_en | output | 1 | Fuse array power enable |
| fuse_rd_en | output | 1 | Fuse byte read request |
| fuse_addr | output | 4 | Fuse byte address |
| fuse_rdata | input | 8 | Fuse byte, valid one cycle after request |
| fuse_prog_en | output | 1 | One-cycle program pulse |
| fuse_prog_addr | output | 4 | Byte to program |
| fuse_prog_bit | output | 3 | Bit to program |
| boot_done | output | 1 | First copy complete (sticky) |

## Verification
The assertions watch, on every cycle, how power, read requests and readiness relate to one another: no read without power, power off whenever the bus is ready, done never falling, and program pulses only to customer bytes and only after an accepted write. Other behaviours can only be shown by the bench's scenarios, because they depend on data held over many cycles. These are the exact 13-cycle copy length, mirror contents that match the fuses, test-mode writes that a reload then erases, refused and locked program requests, and the error flag's persistence.

// File: rtl/otp_mirror_ctrl.sv
module otp_mirror_ctrl #(
  parameter int NBYTES    = 12,
  parameter int AW        = 4,
  parameter int DW        = 8,
  parameter int CUST_LO   = 8,
  parameter int CUST_N    = 2,
  parameter int LOCK_BYTE = 9,
  parameter int LOCK_BIT  = 7,
  parameter int CTRL_ADDR = 12,
  parameter int PROG_ADDR = 13
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  test_mode,
  input  logic                  bus_sel,
  input  logic                  bus_we,
  input  logic [AW-1:0]         bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  output logic                  bus_ready,
  output logic                  fuse_pwr_en,
  output logic                  fuse_rd_en,
  output logic [AW-1:0]         fuse_addr,
  input  logic [DW-1:0]         fuse_rdata,
  output logic                  fuse_prog_en,
  output logic [AW-1:0]         fuse_prog_addr,
  output logic [$clog2(DW)-1:0] fuse_prog_bit,
  output logic                  boot_done
);
  localparam int BW = $clog2(DW);
  localparam int CW = $clog2(NBYTES + 1);

  logic [DW-1:0] mirror [NBYTES];
  logic          busy, done, err, ld_vld;
  logic [CW-1:0] cnt;
  logic [AW-1:0] ld_idx;

  logic [AW-1:0] tgt_byte;
  logic [BW-1:0] tgt_bit;
  logic          wr, locked, cust_hit, prog_req, prog_ok, reload_req, mir_wr, ld_last;

  assign bus_ready   = done & ~busy;
  assign boot_done   = done;
  assign fuse_pwr_en = busy;
  assign fuse_rd_en  = busy & (int'(cnt) < NBYTES);
  assign fuse_addr   = AW'(cnt);

  assign wr         = bus_sel & bus_we & bus_ready;
  assign tgt_byte   = bus_wdata[BW+AW-1:BW];
  assign tgt_bit    = bus_wdata[BW-1:0];
  assign locked     = mirror[LOCK_BYTE][LOCK_BIT];
  assign cust_hit   = (int'(tgt_byte) >= CUST_LO) && (int'(tgt_byte) < CUST_LO + CUST_N);
  assign prog_req   = wr && (int'(bus_addr) == PROG_ADDR);
  assign prog_ok    = prog_req & cust_hit & ~locked;
  assign reload_req = wr && (int'(bus_addr) == CTRL_ADDR) && bus_wdata[0];
  assign mir_wr     = wr & test_mode & (int'(bus_addr) < NBYTES);
  assign ld_last    = ld_vld && (int'(ld_idx) == NBYTES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy           <= 1'b1;
      done           <= 1'b0;
      err            <= 1'b0;
      cnt            <= '0;
      ld_vld         <= 1'b0;
      ld_idx         <= '0;
      fuse_prog_en   <= 1'b0;
      fuse_prog_addr <= '0;
      fuse_prog_bit  <= '0;
    end else begin
      ld_vld       <= fuse_rd_en;
      ld_idx       <= fuse_addr;
      fuse_prog_en <= prog_ok;
      if (fuse_rd_en) cnt <= cnt + 1'b1;
      if (ld_last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
      if (reload_req) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
      if (prog_req && !prog_ok) err <= 1'b1;
      if (prog_ok) begin
        fuse_prog_addr <= tgt_byte;
        fuse_prog_bit  <= tgt_bit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) mirror[i] <= '0;
    end else if (ld_vld) begin
      mirror[ld_idx] <= fuse_rdata;
    end else if (mir_wr) begin
      mirror[bus_addr] <= bus_wdata;
    end else if (prog_ok) begin
      mirror[tgt_byte][tgt_bit] <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (int'(bus_addr) < NBYTES) begin
      if (bus_ready) bus_rdata = mirror[bus_addr];
    end else if (int'(bus_addr) == CTRL_ADDR) begin
      bus_rdata = DW'({err, busy, done});
    end
  end
endmodule

module otp_mirror_ctrl_chk #(
  parameter int NBYTES  = 12,
  parameter int AW      = 4,
  parameter int CUST_LO = 8,
  parameter int CUST_N  = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_ready,
  input logic          boot_done,
  input logic          fuse_pwr_en,
  input logic          fuse_rd_en,
  input logic [AW-1:0] fuse_addr,
  input logic          fuse_prog_en,
  input logic [AW-1:0] fuse_prog_addr
);
  // R3
  rd_needs_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_rd_en |-> fuse_pwr_en);
  // R2
  rd_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_rd_en |-> (int'(fuse_addr) < NBYTES));
  // R2
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done);
  // R4
  ready_after_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> boot_done);
  // R3
  ready_pwr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> !fuse_pwr_en);
  // R3
  pwr_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fuse_pwr_en) |-> boot_done);
  // R10
  prog_cust_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_prog_en |-> (int'(fuse_prog_addr) >= CUST_LO && int'(fuse_prog_addr) < CUST_LO + CUST_N));
  // R7
  prog_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_prog_en |-> $past(bus_ready));
endmodule

bind otp_mirror_ctrl otp_mirror_ctrl_chk #(
  .NBYTES(NBYTES), .AW(AW), .CUST_LO(CUST_LO), .CUST_N(CUST_N)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_ready(bus_ready), .boot_done(boot_done),
  .fuse_pwr_en(fuse_pwr_en), .fuse_rd_en(fuse_rd_en), .fuse_addr(fuse_addr),
  .fuse_prog_en(fuse_prog_en), .fuse_prog_addr(fuse_prog_addr)
);

// File: tb/otp_mirror_ctrl_bench.sv
`timescale 1ns/100ps
module otp_mirror_ctrl_bench;
  localparam realtime PER = 5.0;

  logic       clk = 0, rst_n = 0, test_mode = 0;
  logic       bus_sel = 0, bus_we = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic       bus_ready, fuse_pwr_en, fuse_rd_en, fuse_prog_en, boot_done;
  logic [3:0] fuse_addr, fuse_prog_addr;
  logic [2:0] fuse_prog_bit;
  logic [7:0] fuse_rdata = 0;

  int n_cmp = 0, n_bad = 0, prog_cnt = 0;
  logic [7:0] arr [12];
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         rd_pend = 0;

  always #(PER/2) clk = ~clk;

  otp_mirror_ctrl u_otp_mirror_ctrl (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .fuse_pwr_en(fuse_pwr_en), .fuse_rd_en(fuse_rd_en), .fuse_addr(fuse_addr),
    .fuse_rdata(fuse_rdata), .fuse_prog_en(fuse_prog_en), .fuse_prog_addr(fuse_prog_addr),
    .fuse_prog_bit(fuse_prog_bit), .boot_done(boot_done)
  );

  function automatic logic [7:0] fact(int i);
    return (i == 8 || i == 9) ? 8'h00 : 8'(i * 37 + 5);
  endfunction

  initial for (int i = 0; i < 12; i++) arr[i] = fact(i);

  always @(posedge clk) begin
    if (fuse_rd_en) fuse_rdata <= arr[fuse_addr];
    if (fuse_prog_en) begin
      arr[fuse_prog_addr][fuse_prog_bit] <= 1'b1;
      prog_cnt <= prog_cnt + 1;
    end
  end

  task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
  end

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1;
    bus_sel = 1; bus_we = 0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t); rd_pend = 1;
    @(posedge clk); #1;
    bus_sel = 0; rd_pend = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic wait_after(input realtime t0, input int k);
    while ($realtime < t0 + k * PER) @(negedge clk);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(PER * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    realtime t0;
    int pc;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 boot_done", 8'(boot_done), 8'h0);
    chk("R1 bus_ready", 8'(bus_ready), 8'h0);
    chk("R1 fuse_pwr_en", 8'(fuse_pwr_en), 8'h1);
    rd(4'hC, 8'h02, "R1 status in reset");
    @(posedge clk); #1; rst_n = 1; t0 = $realtime;
    @(negedge clk);
    chk("R4 ready during boot", 8'(bus_ready), 8'h0);
    rd(4'h0, 8'h00, "R4 read before ready");
    wait_after(t0, 12);
    chk("R2 not done at edge 12", 8'(boot_done), 8'h0);
    chk("R3 power on at edge 12", 8'(fuse_pwr_en), 8'h1);
    @(negedge clk);
    chk("R2 done at edge 13", 8'(boot_done), 8'h1);
    chk("R3 power off after copy", 8'(fuse_pwr_en), 8'h0);
    chk("R4 ready after copy", 8'(bus_ready), 8'h1);
    for (int i = 0; i < 12; i++) rd(4'(i), fact(i), "R2 mirror equals fuse");
    rd(4'h8, 8'h00, "R8 blank customer byte 8");
    rd(4'h9, 8'h00, "R8 blank customer byte 9");
    rd(4'hC, 8'h01, "R12 status idle");
    rd(4'hE, 8'h00, "R12 unused location");

    wr(4'h3, 8'hAA);
    rd(4'h3, fact(3), "R5 write ignored outside test mode");
    test_mode = 1;
    wr(4'h3, 8'h5A);
    wr(4'h8, 8'hFF);
    rd(4'h3, 8'h5A, "R5 test-mode write");
    rd(4'h8, 8'hFF, "R5 test-mode write customer byte");
    test_mode = 0;

    pc = prog_cnt;
    wr(4'hC, 8'h01); t0 = $realtime;
    @(negedge clk);
    chk("R6 reload busy", 8'(bus_ready), 8'h0);
    chk("R6 reload power", 8'(fuse_pwr_en), 8'h1);
    wr(4'hC, 8'h01);
    wr(4'hD, 8'h41);
    wait_after(t0, 12);
    chk("R7 reload not restarted", 8'(bus_ready), 8'h0);
    @(negedge clk);
    chk("R6 reload 13 cycles", 8'(bus_ready), 8'h1);
    chk("R6 power off after reload", 8'(fuse_pwr_en), 8'h0);
    chk("R7 program during reload ignored", 8'(prog_cnt - pc), 8'h0);
    rd(4'h3, fact(3), "R6 reload restores byte 3");
    rd(4'h8, 8'h00, "R7 reload restores byte 8, no program bit");

    wr(4'hD, 8'h42);
    rd(4'h8, 8'h04, "R9 program byte 8 bit 2");
    chk("R9 one program pulse", 8'(prog_cnt - pc), 8'h1);
    wr(4'hD, 8'h48);
    rd(4'h9, 8'h01, "R9 program byte 9 bit 0");
    rd(4'hC, 8'h01, "R9 no error on valid program");

    pc = prog_cnt;
    wr(4'hD, 8'h18);
    rd(4'h3, fact(3), "R10 non-customer byte untouched");
    rd(4'hC, 8'h05, "R10 error flag set");
    chk("R10 no pulse", 8'(prog_cnt - pc), 8'h0);

    wr(4'hD, 8'h4F);
    rd(4'h9, 8'h81, "R11 lock bit programmed");
    pc = prog_cnt;
    wr(4'hD, 8'h45);
    rd(4'h8, 8'h04, "R11 locked program ignored");
    chk("R11 no pulse when locked", 8'(prog_cnt - pc), 8'h0);

    wr(4'hC, 8'h01); t0 = $realtime;
    wait_after(t0, 13);
    rd(4'h8, 8'h04, "R9 programmed bit survives reload");
    rd(4'h9, 8'h81, "R9 lock survives reload");
    rd(4'hC, 8'h05, "R10 error sticky across reload");
    repeat (2) @(posedge clk);
    report();
  end
endmodule